// File: doc/BRIEF.md
# Power Stage Reset Sequencer

This block drives the active-low reset of a switching power stage and asks the upstream modulator to start or stop its PWM stream. It keeps the stage in its high-impedance state from power-on. The stage is let out of reset only after two things hold. First, the gate supply has been good for long enough to precharge the bootstrap capacitors. Second, the PWM stream that the stage will receive is switching inside an accepted frequency window.

The block measures every PWM period in system clocks. It treats the stream as usable after a run of consecutive in-window periods. A single bad period, or a stream that stops toggling, pulls the stage back into reset at once. For power-down, and for loss of the gate supply, the stage reset is lowered first. The PWM-enable request to the modulator is withdrawn only after a short hold, so the stage never sees its input stop while it is still switching.

Top module: `pstage_rst_seq`

## Requirements
- R1: During and directly after the synchronous reset `rst`, `stage_rst_n` and `pwm_en_req` are both 0.
- R2: While `gate_supply_ok` is 0, `stage_rst_n` and `pwm_en_req` stay 0, even with a valid PWM stream and `mod_ready` high.
- R3: After `gate_supply_ok` rises, `stage_rst_n` stays 0 for at least PRECHARGE_US microseconds of CLK_HZ clocks (1000 clocks in the bench), even when every other release condition already holds. It rises within a few clocks after that interval ends.
- R4: `stage_rst_n` is released only while `mod_ready` is 1. It drops back to 0 when `mod_ready` falls.
- R5: A PWM period counts as in-window when its length between rising edges is from CLK_HZ/FMAX_HZ to CLK_HZ/FMIN_HZ clocks, both ends included (125 and 142 at 50 MHz). The stream is valid only after 16 consecutive in-window periods.
- R6: A single period shorter or longer than the window clears validity. `stage_rst_n` then falls while `pwm_en_req` stays 1.
- R7: If no rising edge arrives within the maximum period, validity is cleared and `stage_rst_n` falls. This covers a constant high and a constant low on `pwm_in`.
- R8: When `pwr_down_req` is sampled high, `stage_rst_n` is 0 after that same clock edge. `pwm_en_req` stays 1 for exactly 4 further clocks and then goes to 0.
- R9: Loss of `gate_supply_ok` is handled as a power-down (the same order as R8) and restarts the precharge interval from zero.
- R10: `pwm_en_req` is 1 from the first clock edge after `gate_supply_ok` is seen high without a power-down request. `stage_rst_n` is never 1 while `pwm_en_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_supply_ok | input | 1 | Gate-drive supply is within range |
| mod_ready | input | 1 | Modulator is powered and initialized |
| pwm_in | input | 1 | PWM stream as seen by the power stage (asynchronous) |
| pwr_down_req | input | 1 | Request for an ordered shutdown |
| stage_rst_n | output | 1 | Active-low reset to the power stage |
| pwm_en_req | output | 1 | Request to the modulator to stream PWM |

## Verification
The hardest state to reach is a stage that is already released and then sees one period just outside the window. A period 124 or 143 clocks long must be told apart from the in-window 125 and 142. The bench has a free-running PWM generator whose period and mode (switching, stuck low, stuck high) change while the sequencer runs. It moves between the exact window edges without losing lock, then steps one clock past each edge. The precharge gate is isolated by locking the stream before the supply rises, so only the timer can hold the reset.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF,
        SEQ_ARM,
        SEQ_RUN,
        SEQ_DRAIN
    } seq_state_e;

    typedef struct packed {
        logic supply_ok;
        logic precharged;
        logic mod_ready;
        logic pwm_valid;
        logic down_req;
    } seq_cond_t;

    function automatic int unsigned period_cycles(int unsigned clk_hz, int unsigned f_hz);
        return clk_hz / f_hz;
    endfunction

    function automatic int unsigned us_to_cycles(int unsigned clk_hz, int unsigned us);
        return (clk_hz / 1_000_000) * us;
    endfunction

endpackage

// File: rtl/pss_precharge.sv
module pss_precharge #(
    parameter int unsigned CYC = 50_000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == CW'(CYC - 1)) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R9: a supply dip always restarts the interval
    assert_supply_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !done);

endmodule

// File: rtl/pss_pwm_monitor.sv
module pss_pwm_monitor #(
    parameter int unsigned PER_MIN = 125,
    parameter int unsigned PER_MAX = 142,
    parameter int unsigned LOCK    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    output logic pwm_valid
);
    localparam int CW = $clog2(PER_MAX + 1);
    localparam int LW = $clog2(LOCK + 1);

    logic [2:0]    sync_q;
    logic          rise;
    logic [CW-1:0] since;
    logic          armed;
    logic [LW-1:0] good;
    logic          period_ok;
    logic          timeout;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], pwm_in};
    end

    assign rise      = sync_q[1] & ~sync_q[2];
    assign period_ok = (since >= CW'(PER_MIN - 1)) && (since <= CW'(PER_MAX - 1));
    assign timeout   = (since == CW'(PER_MAX));

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= '0;
            armed <= 1'b0;
            good  <= '0;
        end else if (rise) begin
            since <= '0;
            armed <= 1'b1;
            if (armed && period_ok) begin
                if (good != LW'(LOCK)) good <= good + 1'b1;
            end else begin
                good <= '0;
            end
        end else if (timeout) begin
            armed <= 1'b0;
            good  <= '0;
        end else begin
            since <= since + 1'b1;
        end
    end

    assign pwm_valid = (good == LW'(LOCK));

    assert_stall_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (timeout && !rise) |=> !pwm_valid);

    assert_bad_period_R6: assert property (@(posedge clk) disable iff (rst)
        (rise && armed && !period_ok) |=> !pwm_valid);

endmodule

// File: rtl/pstage_rst_seq.sv
module pstage_rst_seq
    import pss_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 50_000_000,
    parameter int unsigned PRECHARGE_US = 1000,
    parameter int unsigned FMIN_HZ      = 350_000,
    parameter int unsigned FMAX_HZ      = 400_000,
    parameter int unsigned LOCK_PERIODS = 16,
    parameter int unsigned EN_HOLD      = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_supply_ok,
    input  logic mod_ready,
    input  logic pwm_in,
    input  logic pwr_down_req,
    output logic stage_rst_n,
    output logic pwm_en_req
);
    localparam int unsigned PRE_CYC = us_to_cycles(CLK_HZ, PRECHARGE_US);
    localparam int unsigned PER_MIN = period_cycles(CLK_HZ, FMAX_HZ);
    localparam int unsigned PER_MAX = period_cycles(CLK_HZ, FMIN_HZ);
    localparam int          HW      = $clog2(EN_HOLD + 1);

    seq_cond_t     cond;
    seq_state_e    state, state_nx;
    logic [HW-1:0] hold_cnt;
    logic          pre_done;
    logic          pwm_valid;

    pss_precharge #(.CYC(PRE_CYC)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (gate_supply_ok),
        .done      (pre_done)
    );

    pss_pwm_monitor #(
        .PER_MIN (PER_MIN),
        .PER_MAX (PER_MAX),
        .LOCK    (LOCK_PERIODS)
    ) u_mon (
        .clk       (clk),
        .rst       (rst),
        .pwm_in    (pwm_in),
        .pwm_valid (pwm_valid)
    );

    assign cond = '{supply_ok:  gate_supply_ok,
                    precharged: pre_done,
                    mod_ready:  mod_ready,
                    pwm_valid:  pwm_valid,
                    down_req:   pwr_down_req};

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_OFF:   if (cond.supply_ok && !cond.down_req) state_nx = SEQ_ARM;
            SEQ_ARM: begin
                if (cond.down_req || !cond.supply_ok)
                    state_nx = SEQ_DRAIN;
                else if (cond.precharged && cond.pwm_valid && cond.mod_ready)
                    state_nx = SEQ_RUN;
            end
            SEQ_RUN: begin
                if (cond.down_req || !cond.supply_ok)
                    state_nx = SEQ_DRAIN;
                else if (!cond.pwm_valid || !cond.mod_ready)
                    state_nx = SEQ_ARM;
            end
            SEQ_DRAIN: if (hold_cnt == HW'(EN_HOLD - 1)) state_nx = SEQ_OFF;
            default:   state_nx = SEQ_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_OFF;
            hold_cnt <= '0;
        end else begin
            state    <= state_nx;
            hold_cnt <= (state == SEQ_DRAIN) ? hold_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        stage_rst_n = (state == SEQ_RUN);
        pwm_en_req  = (state != SEQ_OFF);
    end

    // checker state: clocks spent with reset low and PWM still requested
    logic [HW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (rst) low_run <= '0;
        else if (pwm_en_req && !stage_rst_n) begin
            if (low_run != HW'(EN_HOLD)) low_run <= low_run + 1'b1;
        end else low_run <= '0;
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!stage_rst_n && !pwm_en_req));

    assert_release_gated_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(stage_rst_n) |-> $past(pre_done && pwm_valid && mod_ready));

    assert_en_drop_order_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(pwm_en_req) |-> (low_run >= HW'(EN_HOLD)));

    assert_run_needs_pwm_R10: assert property (@(posedge clk) disable iff (rst)
        stage_rst_n |-> pwm_en_req);

endmodule

// File: tb/pstage_rst_seq_tb.sv
module pstage_rst_seq_tb;
    logic clk = 1'b0;
    logic rst, gate_supply_ok, mod_ready, pwm_in, pwr_down_req;
    logic stage_rst_n, pwm_en_req;

    int n_run  = 0;
    int n_fail = 0;
    int pwm_mode = 0;   // 0 stuck low, 1 switching, 2 stuck high
    int pwm_per  = 130;
    int ph       = 0;

    always #10 clk = ~clk;

    pstage_rst_seq #(.PRECHARGE_US(20)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .gate_supply_ok (gate_supply_ok),
        .mod_ready      (mod_ready),
        .pwm_in         (pwm_in),
        .pwr_down_req   (pwr_down_req),
        .stage_rst_n    (stage_rst_n),
        .pwm_en_req     (pwm_en_req)
    );

    initial begin
        pwm_in = 1'b0;
        forever begin
            @(negedge clk);
            if (pwm_mode == 1) begin
                if (ph >= pwm_per - 1) ph = 0;
                else ph++;
                pwm_in = (ph < pwm_per / 2);
            end else begin
                pwm_in = (pwm_mode == 2);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; gate_supply_ok = 1'b0; mod_ready = 1'b0; pwr_down_req = 1'b0;
        tick(5);
        check("R1", "rst_n in reset", stage_rst_n, 1'b0);
        check("R1", "en in reset", pwm_en_req, 1'b0);
        @(negedge clk); rst = 1'b0;
        tick(1);
        check("R1", "rst_n after reset", stage_rst_n, 1'b0);
    endtask

    task automatic t_no_supply;
        @(negedge clk); pwm_mode = 1; pwm_per = 130; mod_ready = 1'b1;
        tick(3000);
        check("R2", "rst_n without supply", stage_rst_n, 1'b0);
        check("R2", "en without supply", pwm_en_req, 1'b0);
    endtask

    task automatic t_ready_gate;
        @(negedge clk); mod_ready = 1'b0; gate_supply_ok = 1'b1;
        tick(2);
        check("R10", "en after supply", pwm_en_req, 1'b1);
        tick(1500);
        check("R4", "rst_n with modulator not ready", stage_rst_n, 1'b0);
        @(negedge clk); mod_ready = 1'b1;
        tick(3);
        check("R4", "rst_n once ready", stage_rst_n, 1'b1);
        @(negedge clk); mod_ready = 1'b0;
        tick(1);
        check("R4", "rst_n on ready loss", stage_rst_n, 1'b0);
        @(negedge clk); mod_ready = 1'b1;
        tick(3);
        check("R4", "rst_n ready again", stage_rst_n, 1'b1);
    endtask

    task automatic t_power_down;
        @(negedge clk); pwr_down_req = 1'b1;
        tick(1);
        check("R8", "rst_n on request edge", stage_rst_n, 1'b0);
        check("R8", "en on request edge", pwm_en_req, 1'b1);
        for (int i = 1; i <= 3; i++) begin
            tick(1);
            check("R8", "en during hold", pwm_en_req, 1'b1);
        end
        tick(1);
        check("R8", "en after hold", pwm_en_req, 1'b0);
        check("R10", "rst_n while en low", stage_rst_n, 1'b0);
        tick(10);
        check("R8", "en stays off", pwm_en_req, 1'b0);
        @(negedge clk); pwr_down_req = 1'b0;
        tick(3);
        check("R8", "restart after request", stage_rst_n, 1'b1);
    endtask

    task automatic t_supply_loss;
        @(negedge clk); gate_supply_ok = 1'b0;
        tick(1);
        check("R9", "rst_n on supply loss", stage_rst_n, 1'b0);
        check("R9", "en held on supply loss", pwm_en_req, 1'b1);
        tick(10);
        check("R9", "en after supply loss", pwm_en_req, 1'b0);
        @(negedge clk); gate_supply_ok = 1'b1;
        tick(995);
        check("R3", "rst_n inside precharge", stage_rst_n, 1'b0);
        check("R10", "en during precharge", pwm_en_req, 1'b1);
        tick(10);
        check("R3", "rst_n after precharge", stage_rst_n, 1'b1);
    endtask

    task automatic t_out_of_window(input int bad_per, input string tag);
        @(negedge clk); pwm_per = bad_per;
        tick(400);
        check("R6", {tag, " rst_n"}, stage_rst_n, 1'b0);
        check("R6", {tag, " en kept"}, pwm_en_req, 1'b1);
        @(negedge clk); pwm_per = 130;
        tick(2400);
        check("R6", {tag, " recovery"}, stage_rst_n, 1'b1);
    endtask

    task automatic t_window_edges;
        @(negedge clk); pwm_per = 125;
        tick(300);
        check("R5", "min period keeps lock", stage_rst_n, 1'b1);
        tick(2400);
        check("R5", "min period locked", stage_rst_n, 1'b1);
        @(negedge clk); pwm_per = 142;
        tick(300);
        check("R5", "max period keeps lock", stage_rst_n, 1'b1);
        tick(2400);
        check("R5", "max period locked", stage_rst_n, 1'b1);
        @(negedge clk); pwm_per = 130;
        tick(300);
    endtask

    task automatic t_lock_count;
        @(negedge clk); pwm_mode = 0;
        tick(400);
        check("R7", "stuck low drops", stage_rst_n, 1'b0);
        @(negedge clk); pwm_mode = 1; pwm_per = 130;
        tick(1950);
        check("R5", "before 16 periods", stage_rst_n, 1'b0);
        tick(350);
        check("R5", "after 16 periods", stage_rst_n, 1'b1);
    endtask

    task automatic t_stuck_high;
        @(negedge clk); pwm_mode = 2;
        tick(250);
        check("R7", "stuck high drops", stage_rst_n, 1'b0);
        check("R7", "en kept", pwm_en_req, 1'b1);
        @(negedge clk); pwm_mode = 1;
        tick(2400);
        check("R7", "recovery", stage_rst_n, 1'b1);
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_no_supply();
        t_ready_gate();
        t_power_down();
        t_supply_loss();
        t_out_of_window(124, "short period");
        t_out_of_window(143, "long period");
        t_window_edges();
        t_lock_count();
        t_stuck_high();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule